// File: doc/BRIEF.md
# Per-Channel ADC Calibration Datapath

This block corrects raw ADC samples on their way to downstream processing. Each incoming sample comes with a channel number and a prescaler index. Those two identifiers select a gain and offset pair from a local coefficient memory. The block returns the gain-and-offset corrected value, rounded and clamped to the 12-bit sample range. It carries the same identifiers as the input, arrives with a valid strobe and has a fixed delay.

An initialization agent loads two regions at power-up, each through its own single-bit, active-high write enable. The first region holds the per-pair coefficients. The second holds a one-bit table that says whether a pair is corrected at all.

Two per-sample controls change the arithmetic:

- An offset-only mode uses the adder alone and ignores the gain.
- A saturation-bypass option forwards rail-valued samples without change.

Channels at or above the supported count are always forwarded raw.

Top module: `adc_cal_pipe`

## Requirements
- R1: With offset-only mode off, a corrected sample equals floor((x·m + c·16384 + 8192) / 16384), clamped to 0..4095. Here x is the 12-bit unsigned sample, m is the 16-bit unsigned gain with 14 fraction bits, and c is the 16-bit two's-complement offset in sample LSBs.
- R2: With `cfg_offset_only` high for a sample, the stored gain is ignored and the result is x + c, clamped to 0..4095.
- R3: The identity pair m = 0x4000, c = 0 returns every sample value unchanged, including 0 and 4095.
- R4: Rounding is to nearest with halves rounded upward, and results below 0 or above 4095 are clamped to 0 or 4095.
- R5: Each (channel, prescaler) pair has its own coefficients at memory address {chan[4:0], ps[1:0]}. Channels 0..29 are calibratable, and channel numbers 30 and 31 are always forwarded raw.
- R6: A pair whose table bit is 0 forwards the raw sample. The table bit for address `init_addr` is written from `init_map_en` when `init_map_we` is high.
- R7: With `cfg_sat_bypass` high for a sample, an input of 0 or 4095 on a table-enabled pair is forwarded raw. With it low, such a sample is corrected like any other.
- R8: `init_coef_we` writes {`init_gain`, `init_ofs`} to address `init_addr` and leaves the table untouched. `init_map_we` writes only the table bit and leaves the coefficients untouched.
- R9: A sample captured at a rising edge with `in_valid` high appears with `out_valid` high right after the 14th rising edge, counting the capture edge. Back-to-back samples come out back to back, and `out_valid` is never high without a matching input.
- R10: `out_chan` and `out_ps` equal the identifiers of the sample being output.
- R11: While `rst` is high at a rising edge, `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw sample strobe |
| in_sample | input | 12 | Raw unsigned ADC sample |
| in_chan | input | 5 | Channel number of the sample |
| in_ps | input | 2 | Prescaler index of the sample |
| cfg_offset_only | input | 1 | Per-sample offset-only mode |
| cfg_sat_bypass | input | 1 | Per-sample bypass of rail-valued samples |
| init_coef_we | input | 1 | Coefficient region write enable |
| init_map_we | input | 1 | Calibrate-enable table write enable |
| init_addr | input | 7 | Pair address {chan, ps} for writes |
| init_gain | input | 16 | Gain to write, unsigned with 14 fraction bits |
| init_ofs | input | 16 | Signed offset to write |
| init_map_en | input | 1 | Table bit to write |
| out_valid | output | 1 | Corrected sample strobe |
| out_sample | output | 12 | Corrected sample |
| out_chan | output | 5 | Channel tag of the output |
| out_ps | output | 2 | Prescaler tag of the output |

## Verification
A wrong internal state in this block shows up at the outputs 14 cycles after the sample that uses it, not earlier.

- **Corrupted coefficient or table word.** It affects only samples of that one pair, so random traffic has to spread over every channel and prescaler to reach it.
- **Pipeline stage out of step with its neighbours.** It shows as an output whose tags or value belong to the adjacent sample, or as an `out_valid` pulse one cycle off.
- **Faulty rounding or clamp logic.** It needs ties and rail-crossing results to be driven on purpose, since random samples rarely land there.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam int SAMP_W = 12;
  localparam int GAIN_W = 16;
  localparam int FRAC_W = 14;
  localparam int OFS_W  = 16;
  localparam int PROD_W = SAMP_W + GAIN_W;
  localparam int SUM_W  = 32;
  localparam int RES_W  = SUM_W - FRAC_W;

  typedef logic [SAMP_W-1:0] samp_t;

  typedef struct packed {
    logic [GAIN_W-1:0]        gain;
    logic signed [OFS_W-1:0]  ofs;
  } coef_t;
endpackage

// File: rtl/cal_coef_store.sv
module cal_coef_store
  import adc_cal_pkg::*;
#(
  parameter int AW = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          coef_we,
  input  logic          map_we,
  input  logic [AW-1:0] waddr,
  input  coef_t         wcoef,
  input  logic          wmap,
  input  logic [AW-1:0] raddr,
  output coef_t         rcoef,
  output logic          rmap
);
  coef_t coef_mem [DEPTH];
  logic  map_mem  [DEPTH];

  // Two independent RAMs so each region has its own write port enable.
  always_ff @(posedge clk) begin
    if (coef_we) coef_mem[waddr] <= wcoef;
    rcoef <= coef_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (map_we) map_mem[waddr] <= wmap;
    rmap <= map_mem[raddr];
  end
endmodule

// File: rtl/cal_arith.sv
module cal_arith
  import adc_cal_pkg::*;
#(
  parameter int NUM_CH = 30,
  parameter int CH_W   = 5,
  parameter int PS_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            v_i,
  input  samp_t           x_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            oo_i,
  input  logic            sb_i,
  input  coef_t           coef_i,
  input  logic            map_i,
  output logic            v_o,
  output samp_t           y_o,
  output logic [CH_W-1:0] ch_o,
  output logic [PS_W-1:0] ps_o
);
  localparam logic [CH_W:0]                CH_LIM = (CH_W+1)'(NUM_CH);
  localparam logic signed [SUM_W-1:0]      HALF   = SUM_W'(1) << (FRAC_W-1);
  localparam logic signed [RES_W-1:0]      RMAX   = RES_W'((1 << SAMP_W) - 1);

  // stage 2: multiply, bypass decision
  logic                    v2, byp2;
  logic [PROD_W-1:0]       p2;
  logic signed [OFS_W-1:0] o2;
  samp_t                   x2;
  logic [CH_W-1:0]         ch2;
  logic [PS_W-1:0]         ps2;

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v_i;
    p2   <= oo_i ? PROD_W'({x_i, {FRAC_W{1'b0}}})
                 : PROD_W'(x_i) * PROD_W'(coef_i.gain);
    byp2 <= !map_i || ({1'b0, ch_i} >= CH_LIM) ||
            (sb_i && ((x_i == '0) || (x_i == '1)));
    o2   <= coef_i.ofs;
    x2   <= x_i;
    ch2  <= ch_i;
    ps2  <= ps_i;
  end

  // stage 3: add offset and rounding half, drop fraction
  logic signed [SUM_W-1:0] p_ext, o_ext, sum_c;
  always_comb begin
    p_ext = $signed({{(SUM_W-PROD_W){1'b0}}, p2});
    o_ext = $signed({{(SUM_W-OFS_W-FRAC_W){o2[OFS_W-1]}}, o2, {FRAC_W{1'b0}}});
    sum_c = p_ext + o_ext + HALF;
  end

  logic                    v3, byp3;
  logic signed [RES_W-1:0] r3;
  samp_t                   x3;
  logic [CH_W-1:0]         ch3;
  logic [PS_W-1:0]         ps3;

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else     v3 <= v2;
    r3   <= sum_c[SUM_W-1:FRAC_W];
    byp3 <= byp2;
    x3   <= x2;
    ch3  <= ch2;
    ps3  <= ps2;
  end

  // stage 4: clamp and select
  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v3;
    if (byp3)              y_o <= x3;
    else if (r3[RES_W-1])  y_o <= '0;
    else if (r3 > RMAX)    y_o <= '1;
    else                   y_o <= r3[SAMP_W-1:0];
    ch_o <= ch3;
    ps_o <= ps3;
  end
endmodule

// File: rtl/cal_delay.sv
module cal_delay #(
  parameter int W     = 20,
  parameter int DEPTH = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_none
      assign q = d;
    end else begin : g_sr
      logic [W-1:0] sr [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/adc_cal_pipe.sv
module adc_cal_pipe
  import adc_cal_pkg::*;
#(
  parameter int NUM_CH  = 30,
  parameter int NUM_PS  = 4,
  parameter int LATENCY = 14,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int PS_W = $clog2(NUM_PS),
  localparam int AW   = CH_W + PS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] in_sample,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [PS_W-1:0]   in_ps,
  input  logic              cfg_offset_only,
  input  logic              cfg_sat_bypass,
  input  logic              init_coef_we,
  input  logic              init_map_we,
  input  logic [AW-1:0]     init_addr,
  input  logic [GAIN_W-1:0] init_gain,
  input  logic [OFS_W-1:0]  init_ofs,
  input  logic              init_map_en,
  output logic              out_valid,
  output logic [SAMP_W-1:0] out_sample,
  output logic [CH_W-1:0]   out_chan,
  output logic [PS_W-1:0]   out_ps
);
  localparam int CORE = 4;
  localparam int TAIL = LATENCY - CORE;
  localparam int DW   = 1 + SAMP_W + CH_W + PS_W;

  // stage 1: capture, coefficient read in parallel
  logic            v1, oo1, sb1, map1;
  samp_t           x1;
  logic [CH_W-1:0] ch1;
  logic [PS_W-1:0] ps1;
  coef_t           coef1;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    x1  <= in_sample;
    ch1 <= in_chan;
    ps1 <= in_ps;
    oo1 <= cfg_offset_only;
    sb1 <= cfg_sat_bypass;
  end

  cal_coef_store #(.AW(AW)) u_store (
    .clk     (clk),
    .coef_we (init_coef_we),
    .map_we  (init_map_we),
    .waddr   (init_addr),
    .wcoef   ('{gain: init_gain, ofs: init_ofs}),
    .wmap    (init_map_en),
    .raddr   ({in_chan, in_ps}),
    .rcoef   (coef1),
    .rmap    (map1)
  );

  logic            v4;
  samp_t           y4;
  logic [CH_W-1:0] ch4;
  logic [PS_W-1:0] ps4;

  cal_arith #(.NUM_CH(NUM_CH), .CH_W(CH_W), .PS_W(PS_W)) u_arith (
    .clk    (clk),
    .rst    (rst),
    .v_i    (v1),
    .x_i    (x1),
    .ch_i   (ch1),
    .ps_i   (ps1),
    .oo_i   (oo1),
    .sb_i   (sb1),
    .coef_i (coef1),
    .map_i  (map1),
    .v_o    (v4),
    .y_o    (y4),
    .ch_o   (ch4),
    .ps_o   (ps4)
  );

  // pad to the fixed latency
  logic [DW-1:0] tail_q;
  cal_delay #(.W(DW), .DEPTH(TAIL)) u_tail (
    .clk (clk),
    .rst (rst),
    .d   ({v4, y4, ch4, ps4}),
    .q   (tail_q)
  );

  assign {out_valid, out_sample, out_chan, out_ps} = tail_q;
endmodule

// File: rtl/adc_cal_chk.sv
module adc_cal_chk #(
  parameter int NUM_CH  = 30,
  parameter int LATENCY = 14,
  parameter int CH_W    = 5,
  parameter int PS_W    = 2,
  parameter int SAMP_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [SAMP_W-1:0] in_sample,
  input logic [CH_W-1:0]   in_chan,
  input logic [PS_W-1:0]   in_ps,
  input logic              cfg_sat_bypass,
  input logic              out_valid,
  input logic [SAMP_W-1:0] out_sample,
  input logic [CH_W-1:0]   out_chan,
  input logic [PS_W-1:0]   out_ps
);
  localparam int L = LATENCY;

  // shadow history of inputs, one slot per pipeline cycle
  logic [L-1:0]      vh;
  logic [SAMP_W-1:0] xh  [L];
  logic [CH_W-1:0]   chh [L];
  logic [PS_W-1:0]   psh [L];
  logic [L-1:0]      sbh;

  always_ff @(posedge clk) begin
    if (rst) vh <= '0;
    else     vh <= {vh[L-2:0], in_valid};
    sbh    <= {sbh[L-2:0], cfg_sat_bypass};
    xh[0]  <= in_sample;
    chh[0] <= in_chan;
    psh[0] <= in_ps;
    for (int i = 1; i < L; i++) begin
      xh[i]  <= xh[i-1];
      chh[i] <= chh[i-1];
      psh[i] <= psh[i-1];
    end
  end

  // R9: output strobe follows input strobe by exactly LATENCY edges
  a_r9_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vh[L-1]);

  // R10: tags travel with data
  a_r10_tags_follow: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_chan == chh[L-1]) && (out_ps == psh[L-1]));

  // R7: rail samples forwarded raw when bypass requested
  a_r7_sat_bypass: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sbh[L-1] && ((xh[L-1] == '0) || (xh[L-1] == '1)))
      |-> out_sample == xh[L-1]);

  // R5: channels beyond the supported count pass raw
  a_r5_chan_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ({1'b0, chh[L-1]} >= (CH_W+1)'(NUM_CH)))
      |-> out_sample == xh[L-1]);

  // R11: reset clears the output strobe
  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind adc_cal_pipe adc_cal_chk #(
  .NUM_CH(NUM_CH), .LATENCY(LATENCY), .CH_W(CH_W), .PS_W(PS_W),
  .SAMP_W(adc_cal_pkg::SAMP_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .in_chan(in_chan), .in_ps(in_ps), .cfg_sat_bypass(cfg_sat_bypass),
  .out_valid(out_valid), .out_sample(out_sample), .out_chan(out_chan),
  .out_ps(out_ps)
);

// File: tb/tb_adc_cal_pipe.sv
`timescale 1ns/1ps
module tb_adc_cal_pipe;
  localparam int NUM_CH = 30;
  localparam int LAT    = 14;
  localparam int DEPTH  = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] in_sample = '0;
  logic [4:0]  in_chan = '0;
  logic [1:0]  in_ps = '0;
  logic        cfg_offset_only = 1'b0, cfg_sat_bypass = 1'b0;
  logic        init_coef_we = 1'b0, init_map_we = 1'b0, init_map_en = 1'b0;
  logic [6:0]  init_addr = '0;
  logic [15:0] init_gain = '0, init_ofs = '0;
  logic        out_valid;
  logic [11:0] out_sample;
  logic [4:0]  out_chan;
  logic [1:0]  out_ps;

  always #10 clk = ~clk;

  adc_cal_pipe dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_chan(in_chan), .in_ps(in_ps), .cfg_offset_only(cfg_offset_only),
    .cfg_sat_bypass(cfg_sat_bypass), .init_coef_we(init_coef_we),
    .init_map_we(init_map_we), .init_addr(init_addr), .init_gain(init_gain),
    .init_ofs(init_ofs), .init_map_en(init_map_en), .out_valid(out_valid),
    .out_sample(out_sample), .out_chan(out_chan), .out_ps(out_ps)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit started = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  int m_gain [DEPTH];
  int m_ofs  [DEPTH];
  bit m_map  [DEPTH];

  typedef struct { int y; int ch; int ps; int t; } exp_t;
  exp_t  q  [$];
  string tq [$];

  function automatic int f_expect(int x, int ch, int ps, bit oo, bit sb);
    int a = ch * 4 + ps;
    longint acc;
    if (ch >= NUM_CH) return x;
    if (!m_map[a]) return x;
    if (sb && (x == 0 || x == 4095)) return x;
    acc = oo ? (longint'(x) * 16384) : (longint'(x) * m_gain[a]);
    acc = acc + longint'(m_ofs[a]) * 16384 + 8192;
    acc = acc >>> 14;
    if (acc < 0) return 0;
    if (acc > 4095) return 4095;
    return int'(acc);
  endfunction

  task automatic wr_coef(int a, int g, int o);
    @(negedge clk);
    init_addr = 7'(a); init_gain = 16'(g); init_ofs = 16'(o);
    init_coef_we = 1'b1; init_map_en = ~m_map[a];
    m_gain[a] = g; m_ofs[a] = o;
    @(negedge clk);
    init_coef_we = 1'b0;
  endtask

  task automatic wr_map(int a, bit e);
    @(negedge clk);
    init_addr = 7'(a); init_map_en = e; init_map_we = 1'b1;
    init_gain = 16'hBEEF; init_ofs = 16'h1357;
    m_map[a] = e;
    @(negedge clk);
    init_map_we = 1'b0;
  endtask

  task automatic send(int x, int ch, int ps, bit oo, bit sb, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_sample = 12'(x); in_chan = 5'(ch); in_ps = 2'(ps);
    cfg_offset_only = oo; cfg_sat_bypass = sb;
    e.y = f_expect(x, ch, ps, oo, sb); e.ch = ch; e.ps = ps; e.t = cyc;
    q.push_back(e); tq.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst) begin
      if (q.size() > 0 && (cyc - q[0].t) == LAT) begin
        n_tests++;
        if (!out_valid || int'(out_sample) != q[0].y ||
            int'(out_chan) != q[0].ch || int'(out_ps) != q[0].ps) begin
          n_fail++;
          $display("FAIL %s: actual v=%0b y=%0d ch=%0d ps=%0d expected v=1 y=%0d ch=%0d ps=%0d (R9 R10)",
                   tq[0], out_valid, out_sample, out_chan, out_ps,
                   q[0].y, q[0].ch, q[0].ps);
        end
        void'(q.pop_front()); void'(tq.pop_front());
      end else if (out_valid) begin
        n_tests++; n_fail++;
        $display("FAIL R9: actual out_valid=1 expected out_valid=0 at cycle %0d", cyc);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R9 watchdog: actual cycles %0d expected fewer than 100000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C41));
    in_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: actual out_valid=%0b expected 0", out_valid);
    end
    in_valid = 1'b0;
    rst = 1'b0;
    started = 1'b1;

    // load every pair
    for (int a = 0; a < DEPTH; a++) begin
      wr_coef(a, 12288 + int'($urandom % 8192), int'($urandom % 401) - 200);
      wr_map(a, ($urandom % 4) != 0);
    end
    // directed pairs
    wr_coef(0, 16'h4000, 0);      wr_map(0, 1'b1);
    wr_coef(2, 16'h7FFF, 100);    wr_map(2, 1'b1);
    wr_coef(3, 16'h4000, -500);   wr_map(3, 1'b1);
    wr_coef(4, 16'h6000, 0);      wr_map(4, 1'b1);
    wr_coef(7, 16'h5000, 0);      wr_map(7, 1'b0);
    wr_coef(118, 16'h4000, -7);   wr_map(118, 1'b1);
    wr_coef(119, 16'h2000, 7);    wr_map(119, 1'b1);
    // R8: map write carries junk coefficient data, coef write carries flipped map bit
    wr_coef(5, 16'h4800, 20);     wr_map(5, 1'b1);
    wr_map(5, 1'b1);
    wr_map(6, 1'b1);
    wr_coef(6, 16'h3000, -10);

    send(1234, 0, 0, 0, 0, "R3");
    send(0,    0, 0, 0, 0, "R3");
    send(4095, 0, 0, 0, 0, "R3");
    send(1000, 0, 2, 0, 0, "R1");
    send(4000, 0, 2, 0, 0, "R4");
    send(100,  0, 3, 0, 0, "R4");
    send(3,    1, 0, 0, 0, "R4");
    send(1,    1, 0, 0, 0, "R4");
    send(1000, 0, 2, 1, 0, "R2");
    send(4095, 0, 3, 0, 1, "R7");
    send(4095, 0, 3, 0, 0, "R7");
    send(0,    0, 2, 0, 1, "R7");
    send(0,    0, 2, 0, 0, "R7");
    send(1000, 1, 3, 0, 0, "R6");
    send(1000, 29, 3, 0, 0, "R5");
    send(1000, 29, 2, 0, 0, "R5");
    send(1000, 30, 0, 0, 0, "R5");
    send(2222, 31, 3, 0, 0, "R5");
    send(2000, 1, 1, 0, 0, "R8");
    send(2000, 1, 2, 0, 0, "R8");
    idle(3);

    for (int i = 0; i < 400; i++) begin
      int x;
      int sel;
      sel = int'($urandom % 8);
      x = (sel == 0) ? 0 : (sel == 1) ? 4095 : int'($urandom % 4096);
      send(x, int'($urandom % 32), int'($urandom % 4),
           ($urandom % 4) == 0, ($urandom % 2) == 1, "R1");
      if ($urandom % 3 == 0) idle(1);
    end
    idle(LAT + 4);
    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R9: actual %0d outputs missing expected 0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule